// File: doc/BRIEF.md
# NAND Flash Read Front End (Two-Chip, Read-Only)

This block stands in for two small-page NAND flash chips, seen from the device side of a parallel control/data port. Every clock it samples the port's data byte, two active-low chip selects, active-low read and write strobes and two latch-enable bits. It decodes command bytes and address bytes on falling edges of the write strobe and serves one data byte on each falling edge of the read strobe. The bytes come from an external byte-addressed memory read port with one cycle of latency.

Each chip keeps its own read mode, address-cycle counter and 24-bit byte pointer into a 16 MiB region. Pages are 528 bytes long, so the row address is multiplied by 528 rather than shifted. The three read modes start the column at offset 0, 256 or 512 within the page. The block drives the low data byte with an enable, and one ready bit per chip. For a request it cannot serve, it pulses an error flag and leaves all of its state untouched.

Top module: `nfr_front`

## Requirements
- R1: Chip 0 is selected when `bus_in[8]` is 0. Otherwise chip 1 is selected when `bus_in[9]` is 0. When both bits are 1, no port activity changes any state, raises `err` or raises `mem_req`.
- R2: A command is taken on the cycle where `bus_in[11]` (write strobe, active low) falls while `bus_in[13]` (command latch) is 1, with the byte in `bus_in[7:0]`. 0x00, 0x01 and 0x50 select read mode A, B and C and clear the address-cycle counter.
- R3: An address byte is taken on a write-strobe falling edge while `bus_in[12]` (address latch) is 1 and `bus_in[13]` is 0. The first byte after a read command sets the pointer to the byte value. Mode B adds 0x100 to it and mode C adds 0x200.
- R4: The second address byte adds byte×135168 to the pointer, and the third adds byte×528. Both are taken modulo 2^24.
- R5: A read happens when `bus_in[10]` (read strobe, active low) falls while both latch bits are 0 and the write strobe is 1. In that same cycle `mem_req` is 1 and `mem_addr` is {chip, pointer}. The pointer then advances by one.
- R6: After a read, `rdy` of that chip is 0 in the following cycle. One cycle after that, `dout` holds the byte the memory returned, `dout_en` is 1 and `rdy` is high again.
- R7: When the selected chip sees both strobes high, `dout_en` returns to 0 at the next clock edge.
- R8: Command 0xFF returns the chip to the wait state, and an address byte sent in the wait state is rejected.
- R9: These cases each raise `err` for exactly the clock after the event and leave the chip's mode, counter and pointer unchanged: an unknown command, a fourth address byte, an address byte in the wait state, a write-strobe edge with neither latch bit set, and a read-strobe edge with a latch bit set or the write strobe low.
- R10: The two chips hold separate modes, counters and pointers. Activity on one chip never moves the other chip's pointer.
- R11: After reset both chips are in the wait state with pointer 0, `rdy` is 2'b11, and `dout_en`, `err` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 14 | Sampled port: [7:0] data, [8] chip-0 select_n, [9] chip-1 select_n, [10] read strobe_n, [11] write strobe_n, [12] address latch, [13] command latch |
| mem_rdata | input | 8 | Byte returned by the backing memory one cycle after a request |
| mem_req | output | 1 | Read request to the backing memory |
| mem_addr | output | 25 | {chip, 24-bit byte pointer} |
| dout | output | 8 | Data byte for the port's low byte |
| dout_en | output | 1 | Output enable for `dout` |
| rdy | output | 2 | Ready bit per chip (bit 0 is chip 0) |
| err | output | 1 | One-cycle pulse on a rejected request |

## Verification
Several properties are checked on every cycle: a memory request is never made while no chip is selected, a deselected port never raises the error flag, each request is followed by a ready drop, and two cycles later the returned byte appears with its enable. The reset values are also checked every cycle. The bench scenarios cover the rest. They check the pointer arithmetic for each read mode, including the 2^24 wrap. They show that the two chips keep separate pointers, that select priority goes to chip 0, and that rejected commands and address bytes leave the pointer where it was. All of these are visible only through the address of a later read.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

    localparam int PAGE_BYTES = 528;
    localparam int ROW_SPAN   = PAGE_BYTES * 256;
    localparam int NCHIP      = 2;

    typedef enum logic [1:0] {
        RM_WAIT  = 2'd0,
        RM_LOW   = 2'd1,
        RM_MID   = 2'd2,
        RM_SPARE = 2'd3
    } rmode_e;

    typedef struct packed {
        logic       cmd_lt;
        logic       adr_lt;
        logic       wr_n;
        logic       rd_n;
        logic       sel1_n;
        logic       sel0_n;
        logic [7:0] dat;
    } pin_t;

    localparam pin_t PIN_REST = '{cmd_lt: 1'b0, adr_lt: 1'b0, wr_n: 1'b1,
                                  rd_n: 1'b1, sel1_n: 1'b1, sel0_n: 1'b1,
                                  dat: 8'h00};

    typedef struct packed {
        logic       idle;
        logic       cmd;
        logic       adr;
        logic       rd;
        logic       bad;
        logic       chip;
        logic [7:0] val;
    } evt_t;

    function automatic logic cmd_known(input logic [7:0] c);
        return (c == 8'hFF) || (c == 8'h00) || (c == 8'h01) || (c == 8'h50);
    endfunction

    function automatic rmode_e cmd_mode(input logic [7:0] c);
        case (c)
            8'h00:   return RM_LOW;
            8'h01:   return RM_MID;
            8'h50:   return RM_SPARE;
            default: return RM_WAIT;
        endcase
    endfunction

    function automatic logic [9:0] col_base(input rmode_e m, input logic [7:0] b);
        case (m)
            RM_MID:   return {2'b01, b};
            RM_SPARE: return {2'b10, b};
            default:  return {2'b00, b};
        endcase
    endfunction

endpackage

// File: rtl/nfr_decode.sv
module nfr_decode
    import nfr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pin_t pin,
    output evt_t ev
);
    pin_t prev;
    logic sel, wr_fall, rd_fall;

    always_ff @(posedge clk) begin
        if (rst) prev <= PIN_REST;
        else     prev <= pin;
    end

    assign sel     = !pin.sel0_n || !pin.sel1_n;
    assign wr_fall = prev.wr_n && !pin.wr_n;
    assign rd_fall = prev.rd_n && !pin.rd_n;

    always_comb begin
        ev      = '0;
        ev.chip = pin.sel0_n;
        ev.val  = pin.dat;
        if (sel) begin
            ev.idle = pin.rd_n && pin.wr_n;
            ev.cmd  = wr_fall && pin.cmd_lt;
            ev.adr  = wr_fall && !pin.cmd_lt && pin.adr_lt;
            ev.rd   = rd_fall && !pin.cmd_lt && !pin.adr_lt && pin.wr_n;
            ev.bad  = (wr_fall && !pin.cmd_lt && !pin.adr_lt) ||
                      (rd_fall && (pin.cmd_lt || pin.adr_lt || !pin.wr_n));
        end
    end
endmodule

// File: rtl/nfr_chip.sv
module nfr_chip
    import nfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int ID     = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              ev,
    output logic [ADDR_W-1:0] ptr,
    output logic              fault
);
    rmode_e     mode;
    logic [1:0] cyc;
    logic       hit;

    assign hit = (ev.chip == 1'(ID));

    always_comb begin
        fault = 1'b0;
        if (hit) begin
            if (ev.cmd && !cmd_known(ev.val)) fault = 1'b1;
            if (ev.adr && (mode == RM_WAIT || cyc == 2'd3)) fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= RM_WAIT;
            cyc  <= 2'd0;
            ptr  <= '0;
        end else if (hit && !fault) begin
            if (ev.cmd) begin
                if (ev.val == 8'hFF) begin
                    mode <= RM_WAIT;
                end else begin
                    mode <= cmd_mode(ev.val);
                    cyc  <= 2'd0;
                end
            end else if (ev.adr) begin
                cyc <= cyc + 2'd1;
                case (cyc)
                    2'd0:    ptr <= ADDR_W'(col_base(mode, ev.val));
                    2'd1:    ptr <= ptr + ADDR_W'(ev.val) * ADDR_W'(ROW_SPAN);
                    default: ptr <= ptr + ADDR_W'(ev.val) * ADDR_W'(PAGE_BYTES);
                endcase
            end else if (ev.rd) begin
                ptr <= ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nfr_drive.sv
module nfr_drive
    import nfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             ev,
    input  logic [7:0]       mem_rdata,
    output logic [7:0]       dout,
    output logic             dout_en,
    output logic [NCHIP-1:0] rdy
);
    logic pend, pend_chip;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_chip <= 1'b0;
            dout      <= 8'h00;
            dout_en   <= 1'b0;
            rdy       <= '1;
        end else begin
            pend      <= ev.rd;
            pend_chip <= ev.chip;
            if (pend) begin
                dout           <= mem_rdata;
                dout_en        <= 1'b1;
                rdy[pend_chip] <= 1'b1;
            end else if (ev.idle) begin
                dout_en      <= 1'b0;
                rdy[ev.chip] <= 1'b1;
            end
            if (ev.rd) rdy[ev.chip] <= 1'b0;
        end
    end
endmodule

// File: rtl/nfr_front.sv
module nfr_front
    import nfr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [13:0]       bus_in,
    input  logic [7:0]        mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W:0]   mem_addr,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic [1:0]        rdy,
    output logic              err
);
    pin_t              pin;
    evt_t              ev;
    logic [ADDR_W-1:0] ptr_a [NCHIP];
    logic [NCHIP-1:0]  fault;

    assign pin = bus_in;

    nfr_decode u_dec (.clk(clk), .rst(rst), .pin(pin), .ev(ev));

    for (genvar g = 0; g < NCHIP; g++) begin : g_chip
        nfr_chip #(.ADDR_W(ADDR_W), .ID(g)) u_chip (
            .clk(clk), .rst(rst), .ev(ev), .ptr(ptr_a[g]), .fault(fault[g])
        );
    end

    nfr_drive u_drv (
        .clk(clk), .rst(rst), .ev(ev), .mem_rdata(mem_rdata),
        .dout(dout), .dout_en(dout_en), .rdy(rdy)
    );

    assign mem_req  = ev.rd;
    assign mem_addr = {ev.chip, ptr_a[ev.chip]};

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= ev.bad || (|fault);
    end
endmodule

// File: rtl/nfr_checks.sv
module nfr_checks #(
    parameter int ADDR_W = 24
) (
    input logic            clk,
    input logic            rst,
    input logic [13:0]     bus_in,
    input logic [7:0]      mem_rdata,
    input logic            mem_req,
    input logic [ADDR_W:0] mem_addr,
    input logic [7:0]      dout,
    input logic            dout_en,
    input logic [1:0]      rdy,
    input logic            err
);
    // R5: a request only while some chip is selected
    a_r5_req_selected: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (bus_in[9:8] != 2'b11));

    // R1: a deselected port cannot cause an error
    a_r1_idle_no_err: assert property (@(posedge clk) disable iff (rst)
        (bus_in[9:8] == 2'b11) |=> !err);

    // R6: ready drops right after a request
    a_r6_rdy_drop: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> (rdy != 2'b11));

    // R6: returned byte is driven two edges after the request
    a_r6_data_out: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> ##1 (dout_en && dout == $past(mem_rdata)));

    // R11: values right after reset
    a_r11_reset_vals: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdy == 2'b11 && !dout_en && !err));
endmodule

bind nfr_front nfr_checks #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .bus_in(bus_in), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .dout(dout), .dout_en(dout_en),
    .rdy(rdy), .err(err)
);

// File: tb/test_nfr_front.sv
module test_nfr_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] bus = 14'h0F00;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_req;
    logic [24:0] mem_addr;
    logic [7:0]  dout;
    logic        dout_en;
    logic [1:0]  rdy;
    logic        err;
    logic [1:0]  sn_cur = 2'b10;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    nfr_front i_nfr_front (
        .clk(clk), .rst(rst), .bus_in(bus), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .dout(dout),
        .dout_en(dout_en), .rdy(rdy), .err(err)
    );

    function automatic logic [7:0] pat(input logic [24:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ {7'd0, a[24]} ^ 8'h5A;
    endfunction

    always_ff @(posedge clk) if (mem_req) mem_rdata <= pat(mem_addr);

    function automatic logic [24:0] exp_addr(input logic chip, input int off,
                                            input int b0, b1, b2);
        logic [23:0] p;
        p = 24'((b0 | off) + b1 * 135168 + b2 * 528);
        return {chip, p};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic setb(input logic cl, al, w, r, input logic [7:0] d);
        bus = {cl, al, w, r, sn_cur, d};
    endtask

    task automatic we_pulse(input logic cl, al, input logic [7:0] d, output logic e);
        @(negedge clk); setb(cl, al, 1'b1, 1'b1, d);
        @(negedge clk); setb(cl, al, 1'b0, 1'b1, d);
        @(negedge clk); e = err; setb(cl, al, 1'b1, 1'b1, d);
        @(negedge clk); setb(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic rd_pulse(output logic req, output logic [24:0] a,
                            output logic rlow, output logic en,
                            output logic [7:0] d, output logic en_after);
        @(negedge clk); setb(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        #1; req = mem_req; a = mem_addr;
        @(negedge clk); rlow = (rdy != 2'b11);
        @(negedge clk); en = dout_en; d = dout;
        setb(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        @(negedge clk); en_after = dout_en;
        @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] cmd, b0, b1, b2, input string rq);
        logic e;
        we_pulse(1'b1, 1'b0, cmd, e); chk(e == 1'b0, rq, e, 0);
        we_pulse(1'b0, 1'b1, b0, e);  chk(e == 1'b0, rq, e, 0);
        we_pulse(1'b0, 1'b1, b1, e);  chk(e == 1'b0, rq, e, 0);
        we_pulse(1'b0, 1'b1, b2, e);  chk(e == 1'b0, rq, e, 0);
    endtask

    task automatic read_expect(input logic [24:0] ea, input string rq);
        logic req, rlow, en, ea2;
        logic [24:0] a;
        logic [7:0] d;
        rd_pulse(req, a, rlow, en, d, ea2);
        chk(req == 1'b1, {rq, " R5 req"}, req, 1);
        chk(a == ea, {rq, " R5 addr"}, a, ea);
        chk(rlow == 1'b1, "R6 rdy low", rlow, 1);
        chk(en == 1'b1 && d == pat(ea), "R6 data", d, pat(ea));
        chk(ea2 == 1'b0, "R7 release", ea2, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(rdy == 2'b11, "R11 rdy", rdy, 2'b11);
        chk(dout_en == 1'b0 && err == 1'b0 && mem_req == 1'b0, "R11 outs",
            {dout_en, err, mem_req}, 0);
        read_expect(exp_addr(1'b0, 0, 0, 0, 0), "R11 ptr");
    endtask

    task automatic t_mode_a;
        sn_cur = 2'b10;
        setup(8'h00, 8'h10, 8'h02, 8'h03, "R2 R3 R4");
        read_expect(exp_addr(1'b0, 0, 16, 2, 3), "R3 R4");
        read_expect(exp_addr(1'b0, 0, 16, 2, 3) + 25'd1, "R5 incr");
    endtask

    task automatic t_mode_b_chip1;
        sn_cur = 2'b01;
        setup(8'h01, 8'h20, 8'h00, 8'h01, "R2 R10");
        read_expect(exp_addr(1'b1, 'h100, 32, 0, 1), "R3 R1 chip1");
    endtask

    task automatic t_mode_c_wrap;
        sn_cur = 2'b10;
        setup(8'h50, 8'hFF, 8'hFF, 8'hFF, "R2 R4");
        read_expect(exp_addr(1'b0, 'h200, 255, 255, 255), "R4 wrap");
    endtask

    task automatic t_separate;
        sn_cur = 2'b01;
        read_expect(exp_addr(1'b1, 'h100, 32, 0, 1) + 25'd1, "R10 chip1 kept");
        sn_cur = 2'b00;
        read_expect(exp_addr(1'b0, 'h200, 255, 255, 255) + 25'd1, "R1 prio chip0");
    endtask

    task automatic t_deselect;
        logic e, req, rlow, en, ea2;
        logic [24:0] a;
        logic [7:0] d;
        sn_cur = 2'b11;
        we_pulse(1'b1, 1'b0, 8'h42, e);
        chk(e == 1'b0, "R1 no err", e, 0);
        rd_pulse(req, a, rlow, en, d, ea2);
        chk(req == 1'b0, "R1 no req", req, 0);
        sn_cur = 2'b10;
        read_expect(exp_addr(1'b0, 'h200, 255, 255, 255) + 25'd2, "R1 ptr kept");
    endtask

    task automatic t_errors;
        logic e;
        sn_cur = 2'b10;
        we_pulse(1'b1, 1'b0, 8'h42, e);
        chk(e == 1'b1, "R9 unknown cmd", e, 1);
        read_expect(exp_addr(1'b0, 'h200, 255, 255, 255) + 25'd3, "R9 state kept");
        we_pulse(1'b0, 1'b1, 8'h07, e);
        chk(e == 1'b1, "R9 fourth addr", e, 1);
        read_expect(exp_addr(1'b0, 'h200, 255, 255, 255) + 25'd4, "R9 ptr kept");
        we_pulse(1'b0, 1'b0, 8'h00, e);
        chk(e == 1'b1, "R9 no latch", e, 1);
        @(negedge clk); setb(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        @(negedge clk); e = err; setb(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        chk(e == 1'b1, "R9 read with latch", e, 1);
        @(negedge clk);
        chk(err == 1'b0, "R9 single pulse", err, 0);
    endtask

    task automatic t_wait_cmd;
        logic e;
        sn_cur = 2'b10;
        we_pulse(1'b1, 1'b0, 8'hFF, e);
        chk(e == 1'b0, "R8 reset cmd", e, 0);
        we_pulse(1'b0, 1'b1, 8'h05, e);
        chk(e == 1'b1, "R8 addr in wait", e, 1);
        setup(8'h00, 8'h05, 8'h01, 8'h00, "R2 counter cleared");
        read_expect(exp_addr(1'b0, 0, 5, 1, 0), "R8 R2 reentry");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_mode_a;
        t_mode_b_chip1;
        t_mode_c_wrap;
        t_separate;
        t_deselect;
        t_errors;
        t_wait_cmd;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule